// File: doc/BRIEF.md
# White-Balance Statistics Accumulator

This block collects the per-frame numbers an automatic white-balance loop needs. It watches a pixel stream. Each valid beat carries red, green and blue components along with the pixel's luma and saturation. Separate strobes mark the start and the end of a frame.

A pixel counts toward white balance only when both of these hold:
- its luma lies strictly above a programmable floor;
- its saturation lies strictly below a programmable ceiling.

For qualifying pixels the block adds up red, green and blue separately and counts how many there were. Over every pixel of the frame it also forms the mean luma.

The running sums restart on the start strobe. On the end strobe they are copied into held copies. Software reads those copies, together with the two limits, through a byte-wide register port. The limits can also be written through that port. Reads therefore always see one complete frame, never a frame in progress. The mean luma is produced by a short iterative divider that runs after the end strobe.

Top module: `awb_stats_acc`

## Requirements
- R1: After reset the luma floor (address 0x00) reads 100, the saturation ceiling (address 0x01) reads 10, and every statistics byte reads 0.
- R2: A write (`reg_wr` high) to address 0x00 or 0x01 stores `reg_wdata` into the floor or ceiling, and that value reads back. Writes to any other address change nothing.
- R3: A pixel qualifies only if its luma is strictly greater than the floor. A pixel with luma equal to the floor is not summed or counted.
- R4: A pixel qualifies only if its saturation is strictly less than the ceiling. A pixel with saturation equal to the ceiling is not summed or counted.
- R5: The red, green and blue sums of qualifying pixels are each 24 bits wide. Each is read as three bytes, least significant byte first:
  - red at 0x04..0x06;
  - green at 0x08..0x0A;
  - blue at 0x0C..0x0E.
- R6: The qualifying-pixel count is 32 bits wide and is read at 0x10..0x13, least significant byte first.
- R7: `pix_sof` restarts accumulation, and a valid beat in the same cycle is the frame's first pixel. `pix_eof` publishes the totals, including any valid beat in the same cycle. Reads between two end strobes return the previously published frame.
- R8: Each channel sum saturates at 0xFFFFFF instead of wrapping.
- R9: Address 0x02 reads the floor of (sum of luma over all valid beats of the frame) / (number of those beats). A frame with no beats reads 0. The value is in place 8 clock cycles after the end-strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel beat present |
| pix_sof | input | 1 | Frame start strobe |
| pix_eof | input | 1 | Frame end strobe |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_y | input | 8 | Luma |
| pix_s | input | 8 | Saturation |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |

## Verification
The main frame mixes pixels whose luma sits exactly at the floor and one above it, and whose saturation sits exactly at the ceiling and one below it. This separates strict from inclusive comparisons on both limits, and different values per channel catch crossed channels or byte lanes. A second frame is read part-way through, to tell held copies apart from the live sums. An empty frame exercises the zero-divisor case of the average. A long frame of full-scale red exercises saturation against wrap, while green in the same frame shows the other sums still counting.

// File: rtl/awb_stats_acc.sv
module awb_stats_acc #(
  parameter int PIX_W    = 8,
  parameter int SUM_W    = 24,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 5,
  parameter int YLIM_RST = 100,
  parameter int SLIM_RST = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  input  logic [PIX_W-1:0]  pix_y,
  input  logic [PIX_W-1:0]  pix_s,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int YS_W  = CNT_W + PIX_W;
  localparam int STP_W = $clog2(PIX_W + 1);
  localparam int SH_W  = (PIX_W > 1) ? $clog2(PIX_W) : 1;
  localparam int SUM_B = (SUM_W + 7) / 8;
  localparam int CNT_B = (CNT_W + 7) / 8;
  localparam int A_YL = 0, A_SL = 1, A_AVG = 2;
  localparam int A_CH0 = 4, A_CH_STEP = 4, A_CNT = 16;

  logic [PIX_W-1:0] ylim, slim, avg;
  logic [2:0][PIX_W-1:0] comp;
  logic [2:0][SUM_W-1:0] acc, acc_nxt, sh;
  logic [CNT_W-1:0] qcnt, qcnt_nxt, qcnt_sh, fcnt, fcnt_nxt;
  logic [YS_W-1:0]  ysum, ysum_nxt;
  logic qual;

  assign comp = {pix_b, pix_g, pix_r};
  assign qual = pix_valid && (pix_y > ylim) && (pix_s < slim);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [SUM_W-1:0] base;
    logic [SUM_W:0]   add;
    assign base = pix_sof ? '0 : acc[c];
    assign add  = {1'b0, base} + (SUM_W+1)'(comp[c]);
    assign acc_nxt[c] = !qual ? base : (add[SUM_W] ? '1 : add[SUM_W-1:0]);
  end

  logic [CNT_W-1:0] qbase, fbase;
  logic [YS_W-1:0]  ybase;
  logic [CNT_W:0]   qadd, fadd;
  logic [YS_W:0]    yadd;
  assign qbase = pix_sof ? '0 : qcnt;
  assign fbase = pix_sof ? '0 : fcnt;
  assign ybase = pix_sof ? '0 : ysum;
  assign qadd  = {1'b0, qbase} + (CNT_W+1)'(qual);
  assign fadd  = {1'b0, fbase} + (CNT_W+1)'(pix_valid);
  assign yadd  = {1'b0, ybase} + (YS_W+1)'(pix_valid ? pix_y : '0);
  assign qcnt_nxt = qadd[CNT_W] ? '1 : qadd[CNT_W-1:0];
  assign fcnt_nxt = fadd[CNT_W] ? '1 : fadd[CNT_W-1:0];
  assign ysum_nxt = yadd[YS_W]  ? '1 : yadd[YS_W-1:0];

  logic [YS_W-1:0]  rem, trial;
  logic [CNT_W-1:0] den;
  logic [PIX_W-1:0] quo;
  logic [STP_W-1:0] step;
  logic [SH_W-1:0]  shamt;
  logic             fits;
  assign shamt = SH_W'(step - 1'b1);
  assign trial = YS_W'(den) << shamt;
  assign fits  = rem >= trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; sh <= '0; qcnt <= '0; qcnt_sh <= '0; fcnt <= '0; ysum <= '0;
      rem <= '0; den <= '0; quo <= '0; step <= '0; avg <= '0;
    end else begin
      acc  <= acc_nxt;
      qcnt <= qcnt_nxt;
      fcnt <= fcnt_nxt;
      ysum <= ysum_nxt;
      if (pix_eof) begin
        sh      <= acc_nxt;
        qcnt_sh <= qcnt_nxt;
        rem     <= ysum_nxt;
        den     <= fcnt_nxt;
        quo     <= '0;
        step    <= STP_W'(PIX_W);
      end else if (step != '0) begin
        if (fits) begin
          rem        <= rem - trial;
          quo[shamt] <= 1'b1;
        end
        step <= step - 1'b1;
        if (step == STP_W'(1))
          avg <= (den == '0) ? '0 : {quo[PIX_W-1:1], fits};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ylim <= PIX_W'(YLIM_RST);
      slim <= PIX_W'(SLIM_RST);
    end else if (reg_wr) begin
      if (int'(reg_addr) == A_YL) ylim <= PIX_W'(reg_wdata);
      if (int'(reg_addr) == A_SL) slim <= PIX_W'(reg_wdata);
    end
  end

  always_comb begin
    int a;
    a = int'(reg_addr);
    reg_rdata = '0;
    if (a == A_YL)       reg_rdata = 8'(ylim);
    else if (a == A_SL)  reg_rdata = 8'(slim);
    else if (a == A_AVG) reg_rdata = 8'(avg);
    else if (a >= A_CNT && a < A_CNT + CNT_B)
      reg_rdata = 8'(qcnt_sh >> (8 * (a - A_CNT)));
    else
      for (int c = 0; c < 3; c++)
        if (a >= A_CH0 + c*A_CH_STEP && a < A_CH0 + c*A_CH_STEP + SUM_B)
          reg_rdata = 8'(sh[c] >> (8 * (a - A_CH0 - c*A_CH_STEP)));
  end
endmodule

module awb_stats_chk #(
  parameter int PIX_W = 8, SUM_W = 24, CNT_W = 32, ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_valid,
  input logic                  pix_sof,
  input logic                  pix_eof,
  input logic [PIX_W-1:0]      pix_y,
  input logic [PIX_W-1:0]      pix_s,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic                  reg_wr,
  input logic [PIX_W-1:0]      ylim,
  input logic [PIX_W-1:0]      slim,
  input logic [CNT_W-1:0]      qcnt,
  input logic [2:0][SUM_W-1:0] acc,
  input logic [2:0][SUM_W-1:0] sh
);
  AST_YLIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(0)) |=> $stable(ylim)); // R2
  AST_SLIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(1)) |=> $stable(slim)); // R2
  AST_Y_FLOOR_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_sof && pix_y <= ylim) |=> qcnt == $past(qcnt)); // R3
  AST_S_CEIL_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_sof && pix_s >= slim) |=> qcnt == $past(qcnt)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_sof |=> (qcnt - $past(qcnt)) <= CNT_W'(1)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_eof |=> $stable(sh)); // R7
  AST_NO_WRAP_R: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_sof |=> acc[0] >= $past(acc[0])); // R8
  AST_NO_WRAP_G: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_sof |=> acc[1] >= $past(acc[1])); // R8
  AST_NO_WRAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_sof |=> acc[2] >= $past(acc[2])); // R8
endmodule

bind awb_stats_acc awb_stats_chk #(
  .PIX_W(PIX_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .pix_eof(pix_eof), .pix_y(pix_y), .pix_s(pix_s), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .ylim(ylim), .slim(slim), .qcnt(qcnt), .acc(acc), .sh(sh)
);

// File: tb/sim_awb_stats_acc.sv
module sim_awb_stats_acc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_sof = 0, pix_eof = 0;
  logic [7:0] pix_r = 0, pix_g = 0, pix_b = 0, pix_y = 0, pix_s = 0;
  logic [4:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  longint m_ch[3], m_q, m_f, m_y, e_ch[3], e_q, e_avg;
  int ylim_m = 100, slim_m = 10;

  always #2 clk = ~clk;

  awb_stats_acc u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk); reg_addr = 5'(a); #1 v = longint'(reg_rdata);
  endtask

  task automatic rdn(input int a, input int nb, output longint v);
    longint b;
    v = 0;
    for (int i = 0; i < nb; i++) begin rd(a + i, b); v |= b << (8*i); end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pix(input int r, g, b, y, s, input bit sof, eof);
    bit q;
    @(negedge clk);
    pix_valid = 1; pix_sof = sof; pix_eof = eof;
    pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b); pix_y = 8'(y); pix_s = 8'(s);
    if (sof) begin m_ch = '{0,0,0}; m_q = 0; m_f = 0; m_y = 0; end
    q = (y > ylim_m) && (s < slim_m);
    if (q) begin
      m_ch[0] += r; m_ch[1] += g; m_ch[2] += b; m_q++;
      for (int c = 0; c < 3; c++) if (m_ch[c] > 64'hFFFFFF) m_ch[c] = 64'hFFFFFF;
    end
    m_f++; m_y += y;
    if (eof) publish();
  endtask

  task automatic mark(input bit sof, eof);
    @(negedge clk);
    pix_valid = 0; pix_sof = sof; pix_eof = eof;
    if (sof) begin m_ch = '{0,0,0}; m_q = 0; m_f = 0; m_y = 0; end
    if (eof) publish();
  endtask

  function automatic void publish();
    e_ch = m_ch; e_q = m_q; e_avg = (m_f == 0) ? 0 : m_y / m_f;
  endfunction

  task automatic idle(input int n);
    @(negedge clk); pix_valid = 0; pix_sof = 0; pix_eof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_frame(input string tag);
    longint v;
    rdn(4, 3, v);  chk(v == e_ch[0], {"R5 red ", tag}, v, e_ch[0]);
    rdn(8, 3, v);  chk(v == e_ch[1], {"R5 green ", tag}, v, e_ch[1]);
    rdn(12, 3, v); chk(v == e_ch[2], {"R5 blue ", tag}, v, e_ch[2]);
    rdn(16, 4, v); chk(v == e_q, {"R6 count ", tag}, v, e_q);
    rd(2, v);      chk(v == e_avg, {"R9 avg ", tag}, v, e_avg);
  endtask

  task automatic t_reset();
    longint v;
    rd(0, v); chk(v == 100, "R1 floor", v, 100);
    rd(1, v); chk(v == 10, "R1 ceiling", v, 10);
    for (int a = 2; a < 20; a++) begin rd(a, v); chk(v == 0, "R1 stats", v, 0); end
  endtask

  task automatic t_regs();
    longint v;
    wr(0, 55); wr(1, 33);
    rd(0, v); chk(v == 55, "R2 floor write", v, 55);
    rd(1, v); chk(v == 33, "R2 ceiling write", v, 33);
    wr(4, 8'hAB); wr(16, 8'hCD); wr(2, 8'h77);
    rd(4, v);  chk(v == 0, "R2 ro red", v, 0);
    rd(16, v); chk(v == 0, "R2 ro count", v, 0);
    rd(2, v);  chk(v == 0, "R2 ro avg", v, 0);
    wr(0, 100); wr(1, 10);
  endtask

  task automatic t_limits();
    pix(10, 20, 30, 150, 0, 1, 0);
    pix(200, 200, 200, 100, 0, 0, 0); // R3 equal floor: excluded
    pix(1, 2, 3, 101, 9, 0, 0);       // R3/R4 just inside
    pix(99, 99, 99, 200, 10, 0, 0);   // R4 equal ceiling: excluded
    pix(7, 5, 4, 50, 0, 0, 1);
    idle(12);
    check_frame("limits");
    chk(e_q == 2, "R3 R4 model count", e_q, 2);
  endtask

  task automatic t_shadow();
    longint v, old_r;
    old_r = e_ch[0];
    pix(40, 41, 42, 180, 1, 1, 0);
    pix(40, 41, 42, 180, 1, 0, 0);
    idle(3);
    rdn(4, 3, v); chk(v == old_r, "R7 mid-frame read", v, old_r);
    pix(5, 6, 7, 120, 2, 0, 1);
    idle(12);
    check_frame("second frame");
  endtask

  task automatic t_empty();
    mark(1, 0); mark(0, 1); idle(12);
    check_frame("empty");
  endtask

  task automatic t_sat();
    pix(255, 1, 0, 200, 0, 1, 0);
    for (int i = 0; i < 66000; i++) pix(255, 1, 0, 200, 0, 0, 0);
    pix(255, 1, 0, 200, 0, 0, 1);
    idle(12);
    chk(e_ch[0] == 64'hFFFFFF, "R8 model", e_ch[0], 64'hFFFFFF);
    check_frame("saturate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_limits();
    t_shadow();
    t_empty();
    t_sat();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule